// File: doc/BRIEF.md
# SCSI DMA Channel Control Engine

This engine moves bytes between system memory and the byte FIFO of a neighbouring SCSI protocol core. Software loads a transfer length, a starting memory address and, optionally, a descriptor-list pointer through a small indexed register port. It then issues a command byte. The low two bits of that byte choose what the engine does. The top bit chooses the direction, and a 1 there means the device fills memory.

While a transfer runs, the engine presents one byte at a time on a request/acknowledge memory port. After each successful acknowledge it advances a working address and counts a working length down. When the length reaches zero it stops and raises a done flag. A flush command empties whatever the FIFO still holds into memory and reports the end of that drain with its own flag. A memory error halts the channel. An abort command then parks it, and an idle command returns it to rest and clears the sticky flags.

The interrupt line is the OR of the error, abort, done and SCSI-core flags.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset every register reads zero, the status reads 0x00, memReq is low and irq is low.
- R2: The command byte uses bits [1:0] as the operation (00 idle, 01 flush, 10 abort, 11 start) and bit 7 as the direction (1 = FIFO to memory). A start loads the working count (index 3) from the start count (index 1), the working address (index 4) from the start address (index 2) and the working descriptor pointer (index 7) from index 6.
- R3: With direction 1, each byte popped from the FIFO is offered on memWdata at memAddr. Each acknowledge raises the working address by one and lowers the working count by one. The engine pops only when the FIFO level is non-zero.
- R4: With direction 0, memRdata is pushed into the FIFO in the cycle of its acknowledge. No read request starts while fifoFull is high.
- R5: When the working count is zero in a running transfer, status bit 3 (done) sets and requests stop. A start with a zero count sets done without any memory access.
- R6: The status byte has bit 1 error, bit 2 abort, bit 3 done, bit 4 SCSI interrupt, bit 5 flush complete and bit 0 always 0. irq is high exactly when any of bits 1 to 4 is set.
- R7: An idle command clears status bits 1, 2, 3 and 5 and drops any outstanding memReq by the next clock edge.
- R8: An acknowledge with memErr sets status bit 1 and halts the channel with no further requests. A following abort command sets bit 2.
- R9: An abort command while the channel is at rest has no effect: status stays 0x00 and irq stays low.
- R10: A flush command writes every FIFO byte to memory at consecutive working addresses, then sets status bit 5 once the FIFO level is zero. Bit 5 alone does not raise irq.
- R11: scsiIntIn appears in status bit 4 one clock later and raises irq while it stays high.
- R12: Once raised, memReq stays high with memAddr and memWdata unchanged until an acknowledge or a command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regIdx | input | 3 | Register index (0 cmd, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 descriptor pointer, 7 working descriptor pointer) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regIdx, combinational |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write to memory |
| memAddr | output | ADDR_W | Byte address of the request |
| memWdata | output | 8 | Byte written to memory |
| memRdata | input | 8 | Byte read from memory, valid with memAck |
| memAck | input | 1 | Request accepted this cycle |
| memErr | input | 1 | Accepted request failed |
| fifoRdata | input | 8 | Head byte of the SCSI-core FIFO |
| fifoLevel | input | FIFO_LVL_W | Bytes held in the FIFO |
| fifoPop | output | 1 | Remove the head byte |
| fifoFull | input | 1 | FIFO cannot accept a byte |
| fifoPush | output | 1 | Write fifoWdata into the FIFO |
| fifoWdata | output | 8 | Byte for the FIFO |
| scsiIntIn | input | 1 | Interrupt from the SCSI core |
| irq | output | 1 | Interrupt request |

## Verification
Some rules hold on every cycle, and the assertions check those at the ports. A raised request stays put until it is acknowledged. An idle command drops the request and clears the sticky flags. A failed acknowledge stops all further requests. The FIFO is popped only when it holds data and pushed only on a read acknowledge. A read request never starts while the FIFO is full.

Other behaviour depends on a whole sequence and only the directed scenarios can show it. These are the byte-by-byte address and data order of a write transfer, the pushed read data, and done on a zero-length start. The bench also covers the flush drain and its flag, the ignored abort at rest, and the error-then-abort status values.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'b00,
    CMD_FLUSH = 2'b01,
    CMD_ABORT = 2'b10,
    CMD_START = 2'b11
  } cmdOp_e;

  typedef enum logic [2:0] {
    ST_REST,
    ST_RUN,
    ST_FLUSH,
    ST_HALT,
    ST_PARK
  } engState_e;

  typedef struct packed {
    logic loadWork;
    logic stepWork;
    logic latchData;
  } dpStrobe_t;

  localparam logic [2:0] IDX_CMD      = 3'd0;
  localparam logic [2:0] IDX_SCOUNT   = 3'd1;
  localparam logic [2:0] IDX_SADDR    = 3'd2;
  localparam logic [2:0] IDX_WCOUNT   = 3'd3;
  localparam logic [2:0] IDX_WADDR    = 3'd4;
  localparam logic [2:0] IDX_STATUS   = 3'd5;
  localparam logic [2:0] IDX_DESC     = 3'd6;
  localparam logic [2:0] IDX_WDESC    = 3'd7;

  localparam int DIR_BIT = 7;

endpackage

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int FIFO_LVL_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdWr,
  input  cmdOp_e                cmdOp,
  input  logic                  dirWrite,
  input  logic                  memAck,
  input  logic                  memErr,
  input  logic [FIFO_LVL_W-1:0] fifoLevel,
  input  logic                  fifoFull,
  input  logic                  cntZero,
  input  logic                  scsiIntIn,
  output dpStrobe_t             strobe,
  output logic                  memReq,
  output logic                  memWe,
  output logic                  fifoPop,
  output logic                  fifoPush,
  output logic [7:0]            statusVec,
  output logic                  irq
);

  engState_e state;
  logic errSt, abortSt, doneSt, flushSt, scsiSt;
  logic ackGood, moving, fifoHasData, wrIssue, rdIssue;

  assign ackGood     = memReq && memAck && !memErr;
  assign moving      = (state == ST_RUN) || (state == ST_FLUSH);
  assign fifoHasData = (fifoLevel != '0);

  assign wrIssue = !cmdWr && !memReq && fifoHasData &&
                   (((state == ST_RUN) && !cntZero && dirWrite) || (state == ST_FLUSH));
  assign rdIssue = !cmdWr && !memReq && (state == ST_RUN) && !cntZero &&
                   !dirWrite && !fifoFull;

  assign fifoPop  = wrIssue;
  assign fifoPush = (state == ST_RUN) && ackGood && !memWe && !cmdWr;

  assign strobe.loadWork  = cmdWr && (cmdOp == CMD_START);
  assign strobe.stepWork  = moving && ackGood && !cmdWr;
  assign strobe.latchData = wrIssue;

  assign statusVec = {2'b00, flushSt, scsiSt, doneSt, abortSt, errSt, 1'b0};
  assign irq       = errSt | abortSt | doneSt | scsiSt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_REST;
      memReq  <= 1'b0;
      memWe   <= 1'b0;
      errSt   <= 1'b0;
      abortSt <= 1'b0;
      doneSt  <= 1'b0;
      flushSt <= 1'b0;
      scsiSt  <= 1'b0;
    end else begin
      scsiSt <= scsiIntIn;
      if (cmdWr) begin
        case (cmdOp)
          CMD_IDLE: begin
            state   <= ST_REST;
            memReq  <= 1'b0;
            errSt   <= 1'b0;
            abortSt <= 1'b0;
            doneSt  <= 1'b0;
            flushSt <= 1'b0;
          end
          CMD_START: begin
            state   <= ST_RUN;
            memReq  <= 1'b0;
            doneSt  <= 1'b0;
            flushSt <= 1'b0;
          end
          CMD_FLUSH: begin
            state   <= ST_FLUSH;
            memReq  <= 1'b0;
            flushSt <= 1'b0;
          end
          CMD_ABORT: begin
            if (state != ST_REST) begin
              state   <= ST_PARK;
              memReq  <= 1'b0;
              abortSt <= 1'b1;
            end
          end
          default: ;
        endcase
      end else if (memReq && memAck) begin
        memReq <= 1'b0;
        if (memErr) begin
          errSt <= 1'b1;
          state <= ST_HALT;
        end
      end else if (wrIssue) begin
        memReq <= 1'b1;
        memWe  <= 1'b1;
      end else if (rdIssue) begin
        memReq <= 1'b1;
        memWe  <= 1'b0;
      end else if ((state == ST_RUN) && !memReq && cntZero) begin
        doneSt <= 1'b1;
        state  <= ST_REST;
      end else if ((state == ST_FLUSH) && !memReq && !fifoHasData) begin
        flushSt <= 1'b1;
        state   <= ST_REST;
      end
    end
  end

endmodule

// File: rtl/dma_chan_dpath.sv
module dma_chan_dpath
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regIdx,
  input  logic [REG_W-1:0]  regWdata,
  input  dpStrobe_t         strobe,
  input  logic [7:0]        fifoRdata,
  input  logic [7:0]        statusVec,
  output logic              dirWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              cntZero,
  output logic [REG_W-1:0]  regRdata
);

  logic [7:0]        cmdReg;
  logic [CNT_W-1:0]  startCnt, workCnt;
  logic [ADDR_W-1:0] startAddr, workAddr, descAddr, workDesc;
  logic [7:0]        dataLatch;

  assign dirWrite = cmdReg[DIR_BIT];
  assign memAddr  = workAddr;
  assign memWdata = dataLatch;
  assign cntZero  = (workCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg    <= '0;
      startCnt  <= '0;
      startAddr <= '0;
      descAddr  <= '0;
    end else if (regWe) begin
      case (regIdx)
        IDX_CMD:    cmdReg    <= regWdata[7:0];
        IDX_SCOUNT: startCnt  <= regWdata[CNT_W-1:0];
        IDX_SADDR:  startAddr <= regWdata[ADDR_W-1:0];
        IDX_DESC:   descAddr  <= regWdata[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      workCnt  <= '0;
      workAddr <= '0;
      workDesc <= '0;
    end else if (strobe.loadWork) begin
      workCnt  <= startCnt;
      workAddr <= startAddr;
      workDesc <= descAddr;
    end else if (strobe.stepWork) begin
      workAddr <= workAddr + ADDR_W'(1);
      if (!cntZero) workCnt <= workCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 dataLatch <= '0;
    else if (strobe.latchData) dataLatch <= fifoRdata;
  end

  always_comb begin
    case (regIdx)
      IDX_CMD:    regRdata = REG_W'(cmdReg);
      IDX_SCOUNT: regRdata = REG_W'(startCnt);
      IDX_SADDR:  regRdata = REG_W'(startAddr);
      IDX_WCOUNT: regRdata = REG_W'(workCnt);
      IDX_WADDR:  regRdata = REG_W'(workAddr);
      IDX_STATUS: regRdata = REG_W'(statusVec);
      IDX_DESC:   regRdata = REG_W'(descAddr);
      default:    regRdata = REG_W'(workDesc);
    endcase
  end

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 24,
  parameter int FIFO_LVL_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic [2:0]            regIdx,
  input  logic [31:0]           regWdata,
  output logic [31:0]           regRdata,
  output logic                  memReq,
  output logic                  memWe,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [7:0]            memWdata,
  input  logic [7:0]            memRdata,
  input  logic                  memAck,
  input  logic                  memErr,
  input  logic [7:0]            fifoRdata,
  input  logic [FIFO_LVL_W-1:0] fifoLevel,
  output logic                  fifoPop,
  input  logic                  fifoFull,
  output logic                  fifoPush,
  output logic [7:0]            fifoWdata,
  input  logic                  scsiIntIn,
  output logic                  irq
);

  dpStrobe_t  strobe;
  logic       cmdWr, dirWrite, cntZero;
  logic [7:0] statusVec;

  assign cmdWr     = regWe && (regIdx == IDX_CMD);
  assign fifoWdata = memRdata;

  dma_chan_ctrl #(.FIFO_LVL_W(FIFO_LVL_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWr    (cmdWr),
    .cmdOp    (cmdOp_e'(regWdata[1:0])),
    .dirWrite (dirWrite),
    .memAck   (memAck),
    .memErr   (memErr),
    .fifoLevel(fifoLevel),
    .fifoFull (fifoFull),
    .cntZero  (cntZero),
    .scsiIntIn(scsiIntIn),
    .strobe   (strobe),
    .memReq   (memReq),
    .memWe    (memWe),
    .fifoPop  (fifoPop),
    .fifoPush (fifoPush),
    .statusVec(statusVec),
    .irq      (irq)
  );

  dma_chan_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(32)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regIdx   (regIdx),
    .regWdata (regWdata),
    .strobe   (strobe),
    .fifoRdata(fifoRdata),
    .statusVec(statusVec),
    .dirWrite (dirWrite),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .cntZero  (cntZero),
    .regRdata (regRdata)
  );

endmodule

// File: rtl/dma_chan_checker.sv
module dma_chan_checker #(
  parameter int ADDR_W     = 32,
  parameter int FIFO_LVL_W = 5
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWe,
  input logic [2:0]            regIdx,
  input logic [31:0]           regWdata,
  input logic                  memReq,
  input logic                  memWe,
  input logic                  memAck,
  input logic                  memErr,
  input logic [ADDR_W-1:0]     memAddr,
  input logic [7:0]            memWdata,
  input logic                  fifoPop,
  input logic                  fifoPush,
  input logic                  fifoFull,
  input logic [FIFO_LVL_W-1:0] fifoLevel,
  input logic [7:0]            statusVec
);

  logic cmdWrite, idleWrite;
  assign cmdWrite  = regWe && (regIdx == 3'd0);
  assign idleWrite = cmdWrite && (regWdata[1:0] == 2'b00);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !cmdWrite) |=> (memReq && $stable(memAddr) && $stable(memWdata))); // R12

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    idleWrite |=> (!memReq && (statusVec[3:1] == 3'b000) && !statusVec[5])); // R7

  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && memErr && !cmdWrite) |=> (!memReq && statusVec[1])); // R8

  AST_PUSH_ON_ACK: assert property (@(posedge clk) disable iff (!rstN)
    fifoPush |-> (memReq && memAck && !memWe)); // R4

  AST_NO_READ_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(memReq) && !memWe) |-> !$past(fifoFull)); // R4

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> ((fifoLevel != '0) && !memReq)); // R3

  AST_PWR_BIT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusVec[5]) |-> (statusVec[0] == 1'b0 && !memReq)); // R10

endmodule

bind dma_chan_engine dma_chan_checker #(.ADDR_W(ADDR_W), .FIFO_LVL_W(FIFO_LVL_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .regWe    (regWe),
  .regIdx   (regIdx),
  .regWdata (regWdata),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAck   (memAck),
  .memErr   (memErr),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .fifoPop  (fifoPop),
  .fifoPush (fifoPush),
  .fifoFull (fifoFull),
  .fifoLevel(fifoLevel),
  .statusVec(statusVec)
);

// File: tb/dma_chan_engine_tb_top.sv
module dma_chan_engine_tb_top;

  localparam int ADDR_W = 32;
  localparam int LVL_W  = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWe = 1'b0;
  logic [2:0]        regIdx = 3'd0;
  logic [31:0]       regWdata = '0;
  logic [31:0]       regRdata;
  logic              memReq, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [7:0]        memWdata;
  logic [7:0]        memRdata = '0;
  logic              memAck = 1'b0;
  logic              memErr = 1'b0;
  logic [7:0]        fifoRdata;
  logic [LVL_W-1:0]  fifoLevel = '0;
  logic              fifoPop;
  logic              fifoFull = 1'b0;
  logic              fifoPush;
  logic [7:0]        fifoWdata;
  logic              scsiIntIn = 1'b0;
  logic              irq;

  int vecCount = 0;
  int failCount = 0;

  logic [7:0]  fifoMem [0:31];
  logic [4:0]  rdPtr = '0;
  logic [4:0]  wrPtr = '0;
  logic [7:0]  pushLog [0:31];
  int          pushCount = 0;
  logic [31:0] wrAddrLog [0:31];
  logic [7:0]  wrDataLog [0:31];
  int          wrCount = 0;
  int          ackCount = 0;
  logic        ackEnable = 1'b1;
  logic        errArm = 1'b0;

  assign fifoRdata = fifoMem[rdPtr];

  always #4 clk = ~clk;

  dma_chan_engine #(.ADDR_W(ADDR_W), .CNT_W(24), .FIFO_LVL_W(LVL_W)) dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx), .regWdata(regWdata),
    .regRdata(regRdata), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck), .memErr(memErr),
    .fifoRdata(fifoRdata), .fifoLevel(fifoLevel), .fifoPop(fifoPop),
    .fifoFull(fifoFull), .fifoPush(fifoPush), .fifoWdata(fifoWdata),
    .scsiIntIn(scsiIntIn), .irq(irq)
  );

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  // FIFO side: pops and pushes take effect at the edge that samples them
  initial forever begin
    @(posedge clk);
    if (fifoPop) begin
      rdPtr     <= rdPtr + 5'd1;
      fifoLevel <= fifoLevel - 5'd1;
    end
    if (fifoPush) begin
      pushLog[pushCount[4:0]] <= fifoWdata;
      pushCount <= pushCount + 1;
    end
  end

  // memory responder: acknowledges one cycle after a request is seen
  initial forever begin
    @(negedge clk);
    if (memAck) begin
      memAck = 1'b0;
      memErr = 1'b0;
    end else if (memReq && ackEnable) begin
      memAck   = 1'b1;
      memErr   = errArm;
      errArm   = 1'b0;
      memRdata = pat(memAddr);
      ackCount = ackCount + 1;
      if (memWe && !memErr) begin
        wrAddrLog[wrCount[4:0]] = memAddr;
        wrDataLog[wrCount[4:0]] = memWdata;
        wrCount = wrCount + 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    regWe = 1'b1; regIdx = idx; regWdata = val;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] idx, output logic [31:0] val);
    @(negedge clk);
    regIdx = idx;
    #1 val = regRdata;
  endtask

  task automatic waitStatus(input logic [7:0] mask, input string tag);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 200; i++) begin
      regRead(3'd5, v);
      if ((v[7:0] & mask) != 0) break;
    end
    check(tag, {24'd0, v[7:0] & mask} != 0, 32'd1);
  endtask

  task automatic fillFifo(input int n, input logic [7:0] base);
    @(negedge clk);
    for (int i = 0; i < n; i++) fifoMem[wrPtr + 5'(i)] = base + 8'(i);
    wrPtr     = wrPtr + 5'(n);
    fifoLevel = fifoLevel + 5'(n);
  endtask

  task automatic flushFifo();
    @(negedge clk);
    rdPtr     = wrPtr;
    fifoLevel = '0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      regRead(3'(i), v);
      check("R1 register at reset", v, 32'd0);
    end
    check("R1 memReq at reset", {31'd0, memReq}, 32'd0);
    check("R1 irq at reset", {31'd0, irq}, 32'd0);
  endtask

  task automatic testWriteXfer();
    logic [31:0] v;
    int w0;
    w0 = wrCount;
    regWrite(3'd0, 32'h80);
    regWrite(3'd1, 32'd3);
    regWrite(3'd2, 32'h100);
    regWrite(3'd6, 32'hABC);
    regWrite(3'd0, 32'h83);
    regRead(3'd3, v); check("R2 working count loaded", v, 32'd3);
    regRead(3'd4, v); check("R2 working address loaded", v, 32'h100);
    regRead(3'd7, v); check("R2 working descriptor loaded", v, 32'hABC);
    fillFifo(3, 8'hA1);
    waitStatus(8'h08, "R5 done after write transfer");
    check("R3 bytes written", wrCount - w0, 32'd3);
    for (int i = 0; i < 3; i++) begin
      check("R3 write address", wrAddrLog[5'(w0 + i)], 32'h100 + 32'(i));
      check("R3 write data", {24'd0, wrDataLog[5'(w0 + i)]}, 32'hA1 + 32'(i));
    end
    regRead(3'd3, v); check("R3 working count end", v, 32'd0);
    regRead(3'd4, v); check("R3 working address end", v, 32'h103);
    regRead(3'd5, v); check("R6 status done only", v, 32'h08);
    check("R6 irq from done", {31'd0, irq}, 32'd1);
    regWrite(3'd0, 32'h80);
    regRead(3'd5, v); check("R7 idle clears done", v, 32'h00);
    check("R7 irq after idle", {31'd0, irq}, 32'd0);
  endtask

  task automatic testReadXfer();
    int a0, p0;
    a0 = ackCount; p0 = pushCount;
    fifoFull = 1'b1;
    regWrite(3'd0, 32'h00);
    regWrite(3'd1, 32'd2);
    regWrite(3'd2, 32'h200);
    regWrite(3'd0, 32'h03);
    repeat (10) @(negedge clk);
    check("R4 no request while full", ackCount - a0, 32'd0);
    check("R4 memReq low while full", {31'd0, memReq}, 32'd0);
    fifoFull = 1'b0;
    waitStatus(8'h08, "R5 done after read transfer");
    check("R4 bytes pushed", pushCount - p0, 32'd2);
    check("R4 first pushed byte", {24'd0, pushLog[5'(p0)]}, {24'd0, pat(32'h200)});
    check("R4 second pushed byte", {24'd0, pushLog[5'(p0 + 1)]}, {24'd0, pat(32'h201)});
    regWrite(3'd0, 32'h00);
  endtask

  task automatic testZeroCount();
    logic [31:0] v;
    int a0;
    a0 = ackCount;
    regWrite(3'd1, 32'd0);
    regWrite(3'd2, 32'h300);
    regWrite(3'd0, 32'h83);
    repeat (3) @(negedge clk);
    regRead(3'd5, v); check("R5 zero count sets done", v, 32'h08);
    check("R5 zero count no access", ackCount - a0, 32'd0);
    regWrite(3'd0, 32'h80);
  endtask

  task automatic testError();
    logic [31:0] v;
    int a0;
    flushFifo();
    regWrite(3'd1, 32'd2);
    regWrite(3'd2, 32'h500);
    errArm = 1'b1;
    regWrite(3'd0, 32'h83);
    fillFifo(2, 8'hE0);
    waitStatus(8'h02, "R8 error flag set");
    a0 = ackCount;
    repeat (6) @(negedge clk);
    check("R8 no request after error", ackCount - a0, 32'd0);
    regRead(3'd5, v); check("R8 status after error", v, 32'h02);
    check("R6 irq from error", {31'd0, irq}, 32'd1);
    regWrite(3'd0, 32'h82);
    regRead(3'd5, v); check("R8 abort after error", v, 32'h06);
    regWrite(3'd0, 32'h80);
    regRead(3'd5, v); check("R7 idle clears error and abort", v, 32'h00);
    flushFifo();
  endtask

  task automatic testAbortAtRest();
    logic [31:0] v;
    regWrite(3'd0, 32'h02);
    regRead(3'd5, v); check("R9 abort at rest ignored", v, 32'h00);
    check("R9 irq stays low", {31'd0, irq}, 32'd0);
    regWrite(3'd0, 32'h00);
  endtask

  task automatic testScsiInt();
    logic [31:0] v;
    @(negedge clk); scsiIntIn = 1'b1;
    @(negedge clk);
    regRead(3'd5, v); check("R11 scsi flag follows input", v, 32'h10);
    check("R11 irq from scsi", {31'd0, irq}, 32'd1);
    @(negedge clk); scsiIntIn = 1'b0;
    @(negedge clk);
    regRead(3'd5, v); check("R11 scsi flag clears", v, 32'h00);
  endtask

  task automatic testHoldAndIdleDrop();
    logic [31:0] a;
    ackEnable = 1'b0;
    regWrite(3'd1, 32'd5);
    regWrite(3'd2, 32'h400);
    regWrite(3'd0, 32'h03);
    repeat (3) @(negedge clk);
    check("R12 request raised", {31'd0, memReq}, 32'd1);
    a = memAddr;
    check("R12 request address", a, 32'h400);
    repeat (4) @(negedge clk);
    check("R12 request held", {31'd0, memReq}, 32'd1);
    check("R12 address held", memAddr, a);
    regWrite(3'd0, 32'h00);
    check("R7 idle drops request", {31'd0, memReq}, 32'd0);
    repeat (3) @(negedge clk);
    check("R7 request stays dropped", {31'd0, memReq}, 32'd0);
    ackEnable = 1'b1;
  endtask

  task automatic testFlush();
    logic [31:0] v;
    int w0;
    regWrite(3'd1, 32'd0);
    regWrite(3'd2, 32'h300);
    regWrite(3'd0, 32'h83);
    repeat (3) @(negedge clk);
    regWrite(3'd0, 32'h80);
    flushFifo();
    fillFifo(2, 8'hC1);
    w0 = wrCount;
    regWrite(3'd0, 32'h81);
    waitStatus(8'h20, "R10 flush complete flag");
    check("R10 bytes drained", wrCount - w0, 32'd2);
    check("R10 first drain address", wrAddrLog[5'(w0)], 32'h300);
    check("R10 second drain address", wrAddrLog[5'(w0 + 1)], 32'h301);
    check("R10 first drain data", {24'd0, wrDataLog[5'(w0)]}, 32'hC1);
    check("R10 second drain data", {24'd0, wrDataLog[5'(w0 + 1)]}, 32'hC2);
    regRead(3'd5, v); check("R10 status flush only", v, 32'h20);
    check("R10 flush does not raise irq", {31'd0, irq}, 32'd0);
    check("R10 fifo emptied", {27'd0, fifoLevel}, 32'd0);
    regWrite(3'd0, 32'h00);
    regRead(3'd5, v); check("R7 idle clears flush flag", v, 32'h00);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) fifoMem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWriteXfer();
    testReadXfer();
    testZeroCount();
    testError();
    testAbortAtRest();
    testScsiInt();
    testHoldAndIdleDrop();
    testFlush();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule